// File: doc/BRIEF.md
# External Interrupt Trigger Configuration Unit

This unit takes a small set of asynchronous external interrupt pins and turns each one into a request that a parent interrupt controller can consume. Each line has its own trigger mode, chosen by software through a simple register bus. The mode is made from three independent control bits: level-sense, polarity and both-edge. Together they select falling edge, rising edge, either edge, active-low level or active-high level.

The pins first pass through a two-flop synchroniser. In the edge modes a detected transition sets a sticky pending flag, which holds until software acknowledges it by writing one to the line's clear bit. In the level modes the request follows the synchronised pin directly and no pending state is kept. A per-line mask bit gates the request output. Pending edges are still captured while a line is masked, so an edge that arrives during that time is not lost.

Configuration is packed four lines to a 32-bit register. Register 0 holds lines 0 to 3 and register 1 holds lines 4 and up. Software updates one line with a read-modify-write of the register that contains it.

Top module: `ext_irq_trigger`

## Requirements
- R1: After reset every line reads back as active-low level mode (level-sense 1, polarity 0, both-edge 0) with its mask bit 0, and every request output is low.
- R2: Line L is configured in the byte at bits [8*(L mod 4) +: 8] of the register at address L/4. Within that byte, bit 0 is level-sense, bit 1 is polarity, bit 2 is both-edge, bit 3 is mask and bit 4 is clear. Bits 5 to 7, byte slots with no line behind them, and unmapped addresses read as zero, and writes to them have no effect.
- R3: The clear bit acts as a single-cycle acknowledge when written with one and always reads back as zero.
- R4: Each pin passes through two synchronising flops. In a level mode, a pin change driven before a clock edge appears on the request after the second rising edge and not after the first.
- R5: With level-sense 1 and both-edge 0, the request equals the mask AND (synchronised pin == polarity bit).
- R6: With level-sense 0 and both-edge 0, a rising edge (polarity 1) or a falling edge (polarity 0) of the synchronised pin sets the line's pending flag on the following clock edge. The flag stays set across later pin activity until it is cleared.
- R7: With both-edge 1, either transition sets pending, whatever the level-sense and polarity bits hold.
- R8: Writing one to a line's clear bit drops its pending flag. If a qualifying edge is detected in the same cycle as the clear, the edge wins and the flag stays set.
- R9: In edge modes the request is pending AND mask. Edges that arrive while the line is masked still latch and appear on the request as soon as the mask bit is set.
- R10: While a line is in a level mode its pending flag is held clear. A pending edge does not survive a switch to a level mode and back.
- R11: The line count is a parameter (4 or 6). Lines are independent, so configuring, toggling or clearing one line never changes another line's request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin_i | input | NUM_LINES | Asynchronous external interrupt pins |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register word address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data for bus_addr_i (combinational) |
| irq_req_o | output | NUM_LINES | Per-line latched or level request |

## Verification
The hardest case to reach is a clear write landing in exactly the cycle that a synchronised edge is detected. The edge becomes visible only two clocks after the pin moves, so the bench counts those synchroniser stages and places the clear strobe on the third edge after the pin toggle. It does this in both-edge mode with a flag already pending. A second hard-to-see case is a pending flag surviving a round trip through a level mode. The bench reaches it by switching modes on back-to-back writes and then reading the request in the restored edge mode.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

    localparam int SLOT_W        = 8;
    localparam int SLOTS_PER_REG = 4;
    localparam int REG_W         = SLOT_W * SLOTS_PER_REG;

    // field positions inside one line's byte slot
    localparam int BIT_LVL  = 0;
    localparam int BIT_POL  = 1;
    localparam int BIT_BOTH = 2;
    localparam int BIT_MASK = 3;
    localparam int BIT_CLR  = 4;

    typedef struct packed {
        logic both;
        logic pol;
        logic lvl;
    } trig_mode_t;

    typedef struct packed {
        logic       mask;
        trig_mode_t mode;
    } line_cfg_t;

    typedef enum logic [2:0] {
        TRIG_FALL,
        TRIG_RISE,
        TRIG_BOTH,
        TRIG_LVL_LO,
        TRIG_LVL_HI
    } trig_kind_t;

    localparam line_cfg_t CFG_RESET = '{mask: 1'b0,
                                        mode: '{both: 1'b0, pol: 1'b0, lvl: 1'b1}};

    // both-edge dominates, then level-sense, then edge polarity
    function automatic trig_kind_t decode_mode(trig_mode_t m);
        trig_kind_t k;
        if (m.both)
            k = TRIG_BOTH;
        else if (m.lvl)
            k = m.pol ? TRIG_LVL_HI : TRIG_LVL_LO;
        else
            k = m.pol ? TRIG_RISE : TRIG_FALL;
        return k;
    endfunction

    function automatic logic is_edge_kind(trig_kind_t k);
        return (k == TRIG_FALL) || (k == TRIG_RISE) || (k == TRIG_BOTH);
    endfunction

    function automatic logic [SLOT_W-1:0] pack_slot(line_cfg_t c);
        logic [SLOT_W-1:0] s;
        s           = '0;
        s[BIT_LVL]  = c.mode.lvl;
        s[BIT_POL]  = c.mode.pol;
        s[BIT_BOTH] = c.mode.both;
        s[BIT_MASK] = c.mask;
        return s;
    endfunction

    function automatic line_cfg_t unpack_slot(logic [SLOT_W-1:0] s);
        line_cfg_t c;
        c.mode.lvl  = s[BIT_LVL];
        c.mode.pol  = s[BIT_POL];
        c.mode.both = s[BIT_BOTH];
        c.mask      = s[BIT_MASK];
        return c;
    endfunction

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
    import eirq_pkg::*;
#(
    parameter int NUM_LINES = 6,
    parameter int ADDR_W    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [REG_W-1:0]  bus_wdata_i,
    output logic [REG_W-1:0]  bus_rdata_o,
    output line_cfg_t         cfg_o [NUM_LINES],
    output logic [NUM_LINES-1:0] clr_o
);
    line_cfg_t cfg_q [NUM_LINES];
    logic [NUM_LINES-1:0] hit_w;

    // reserved write bits are dropped on purpose
    logic unused_wbits;
    assign unused_wbits = ^bus_wdata_i;

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        localparam int REG_IDX = l / SLOTS_PER_REG;
        localparam int BASE    = (l % SLOTS_PER_REG) * SLOT_W;

        assign hit_w[l] = bus_we_i && (bus_addr_i == ADDR_W'(REG_IDX));
        assign clr_o[l] = hit_w[l] && bus_wdata_i[BASE + BIT_CLR];

        always_ff @(posedge clk) begin
            if (rst)
                cfg_q[l] <= CFG_RESET;
            else if (hit_w[l])
                cfg_q[l] <= unpack_slot(bus_wdata_i[BASE +: SLOT_W]);
        end

        assign cfg_o[l] = cfg_q[l];

        // R1
        default_mode_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(rst) |-> (cfg_q[l] == CFG_RESET));

        // R2
        mask_write_chk: assert property (@(posedge clk) disable iff (rst)
            hit_w[l] |=> (cfg_q[l].mask == $past(bus_wdata_i[BASE + BIT_MASK])));
    end

    always_comb begin
        bus_rdata_o = '0;
        for (int l = 0; l < NUM_LINES; l++) begin
            if (bus_addr_i == ADDR_W'(l / SLOTS_PER_REG))
                bus_rdata_o[(l % SLOTS_PER_REG) * SLOT_W +: SLOT_W] = pack_slot(cfg_q[l]);
        end
    end
endmodule

// File: rtl/eirq_detect.sv
module eirq_detect
    import eirq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_s_i,
    input  line_cfg_t cfg_i,
    input  logic      clr_i,
    output logic      req_o
);
    trig_kind_t kind;
    logic       edge_mode;
    logic       prev_q;
    logic       pend_q;
    logic       rise, fall, evt;
    logic       level_hit;

    assign kind      = decode_mode(cfg_i.mode);
    assign edge_mode = is_edge_kind(kind);
    assign rise      = pin_s_i & ~prev_q;
    assign fall      = ~pin_s_i & prev_q;

    always_comb begin
        unique case (kind)
            TRIG_RISE: evt = rise;
            TRIG_FALL: evt = fall;
            TRIG_BOTH: evt = rise | fall;
            default:   evt = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= pin_s_i;
            // a new edge outranks a simultaneous acknowledge
            pend_q <= edge_mode ? ((pend_q & ~clr_i) | evt) : 1'b0;
        end
    end

    assign level_hit = (pin_s_i == cfg_i.mode.pol);
    assign req_o     = cfg_i.mask & (edge_mode ? pend_q : level_hit);

    // R6
    pend_set_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_mode && evt) |=> pend_q);

    // R6
    pend_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_mode && pend_q && !clr_i) |=> pend_q);

    // R8
    pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q && clr_i && !evt) |=> !pend_q);

    // R10
    level_no_pend_chk: assert property (@(posedge clk) disable iff (rst)
        !edge_mode |=> !pend_q);
endmodule

// File: rtl/ext_irq_trigger.sv
module ext_irq_trigger
    import eirq_pkg::*;
#(
    parameter int NUM_LINES   = 6,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_pin_i,
    input  logic                 bus_we_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [REG_W-1:0]     bus_wdata_i,
    output logic [REG_W-1:0]     bus_rdata_o,
    output logic [NUM_LINES-1:0] irq_req_o
);
    localparam int NUM_REGS = (NUM_LINES + SLOTS_PER_REG - 1) / SLOTS_PER_REG;

    logic [NUM_LINES-1:0] pin_s;
    logic [NUM_LINES-1:0] clr;
    line_cfg_t            cfg [NUM_LINES];

    initial begin
        if (NUM_LINES != 4 && NUM_LINES != 6)
            $error("NUM_LINES must be 4 or 6");
        if ((1 << ADDR_W) < NUM_REGS)
            $error("ADDR_W too small for the configuration registers");
    end

    eirq_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (irq_pin_i),
        .sync_o  (pin_s)
    );

    eirq_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_we_i    (bus_we_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .cfg_o       (cfg),
        .clr_o       (clr)
    );

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_det
        eirq_detect u_det (
            .clk     (clk),
            .rst     (rst),
            .pin_s_i (pin_s[l]),
            .cfg_i   (cfg[l]),
            .clr_i   (clr[l]),
            .req_o   (irq_req_o[l])
        );
    end
endmodule

// File: tb/ext_irq_trigger_bench.sv
`timescale 1ns/1ps
module ext_irq_trigger_bench;
    localparam int NL = 6;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NL-1:0] pins = '0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NL-1:0] req;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] shadow [2];

    always #2 clk = ~clk;

    ext_irq_trigger #(.NUM_LINES(NL), .ADDR_W(AW)) u_ext_irq_trigger (
        .clk(clk), .rst(rst), .irq_pin_i(pins), .bus_we_i(we),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .irq_req_o(req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_write(input int a, input logic [31:0] d);
        we = 1'b1; addr = AW'(a); wdata = d;
        @(posedge clk); @(negedge clk);
        we = 1'b0;
    endtask

    // mode codes: 0 fall, 1 rise, 2 both, 3 level low, 4 level high
    function automatic logic [7:0] mode_byte(input int m, input logic mask);
        logic [7:0] b;
        case (m)
            0: b = 8'h00;
            1: b = 8'h02;
            2: b = 8'h04;
            3: b = 8'h01;
            default: b = 8'h03;
        endcase
        b[3] = mask;
        return b;
    endfunction

    task automatic set_line(input int l, input logic [7:0] b);
        shadow[l/4][(l%4)*8 +: 8] = b & 8'h0F;
        bus_write(l/4, shadow[l/4]);
    endtask

    task automatic clear_line(input int l);
        logic [31:0] d;
        d = shadow[l/4];
        d[(l%4)*8 + 4] = 1'b1;
        bus_write(l/4, d);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        shadow[0] = 32'h01010101;
        shadow[1] = 32'h00000101;
        tick(5);
        rst = 1'b0;
        tick(1);

        // R1 reset state
        addr = 2'd0; #0.1;
        check("R1 reg0 reset", rdata, 32'h01010101);
        addr = 2'd1; #0.1;
        check("R1 reg1 reset", rdata, 32'h00000101);
        check("R1 req reset", 32'(req), 32'h0);

        // R2 reserved bits and R3 clear reads zero
        bus_write(1, 32'hFFFF_FFFF);
        addr = 2'd1; #0.1;
        check("R2 R3 reg1 readback", rdata, 32'h00000F0F);
        addr = 2'd2; #0.1;
        check("R2 unmapped read", rdata, 32'h0);
        bus_write(2, 32'hFFFF_FFFF);
        addr = 2'd0; #0.1;
        check("R2 unmapped write", rdata, 32'h01010101);
        bus_write(1, 32'h00000101);
        tick(3);

        // R4 level latency through two synchroniser flops
        set_line(0, mode_byte(4, 1'b1));
        tick(3);
        pins[0] = 1'b1;
        tick(1);
        check("R4 after one edge", 32'(req), 32'h0);
        tick(1);
        check("R4 after two edges", 32'(req), 32'h1);
        pins[0] = 1'b0;
        tick(3);
        set_line(0, 8'h01);
        tick(3);

        // R5 R6 R7 R11 sweep over every line and mode
        for (int l = 0; l < NL; l++) begin
            for (int m = 0; m < 5; m++) begin
                logic lvl, pol, e_rise, e_fall, exp;
                lvl    = (m >= 3);
                pol    = (m == 1) || (m == 4);
                e_rise = (m == 1) || (m == 2);
                e_fall = (m == 0) || (m == 2);
                set_line(l, mode_byte(m, 1'b1));
                tick(4);
                clear_line(l);
                exp = lvl ? (pol == 1'b0) : 1'b0;
                check($sformatf("R5 R11 idle l%0d m%0d", l, m), 32'(req), exp ? (32'h1 << l) : 0);
                pins[l] = 1'b1;
                tick(3);
                exp = lvl ? pol : e_rise;
                check($sformatf("R5 R6 R7 high l%0d m%0d", l, m), 32'(req), exp ? (32'h1 << l) : 0);
                pins[l] = 1'b0;
                tick(3);
                exp = lvl ? ~pol : (e_rise | e_fall);
                check($sformatf("R5 R6 R7 low l%0d m%0d", l, m), 32'(req), exp ? (32'h1 << l) : 0);
                clear_line(l);
                exp = lvl ? ~pol : 1'b0;
                check($sformatf("R3 R8 clear l%0d m%0d", l, m), 32'(req), exp ? (32'h1 << l) : 0);
                set_line(l, 8'h01);
                tick(3);
            end
        end

        // R7 both-edge overrides level-sense and polarity
        set_line(1, 8'h0F);
        tick(3);
        clear_line(1);
        pins[1] = 1'b1;
        tick(3);
        check("R7 both with lvl pol set", 32'(req), 32'h2);
        set_line(1, 8'h01);
        pins[1] = 1'b0;
        tick(3);

        // R9 edge latches while masked
        pins[2] = 1'b1;
        tick(3);
        set_line(2, mode_byte(0, 1'b0));
        tick(2);
        pins[2] = 1'b0;
        tick(3);
        check("R9 masked hides pending", 32'(req), 32'h0);
        set_line(2, mode_byte(0, 1'b1));
        check("R9 unmask shows pending", 32'(req), 32'h4);
        clear_line(2);
        set_line(2, 8'h01);
        tick(2);

        // R8 clear in the same cycle as a new edge: edge wins
        set_line(3, mode_byte(2, 1'b1));
        tick(3);
        clear_line(3);
        pins[3] = 1'b1;
        tick(3);
        check("R8 pending before race", 32'(req), 32'h8);
        pins[3] = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        clear_line(3);
        check("R8 edge beats clear", 32'(req), 32'h8);
        clear_line(3);
        check("R8 plain clear", 32'(req), 32'h0);

        // R10 pending dropped by a level-mode round trip
        pins[3] = 1'b1;
        tick(3);
        check("R10 pending set", 32'(req), 32'h8);
        set_line(3, mode_byte(3, 1'b1));
        check("R10 level low with pin high", 32'(req), 32'h0);
        set_line(3, mode_byte(2, 1'b1));
        check("R10 pending gone after return", 32'(req), 32'h0);
        set_line(3, 8'h01);
        pins[3] = 1'b0;
        tick(3);

        finish_run();
    end
endmodule